// File: doc/BRIEF.md
# Synchronous Rectification Gate Selector

This block sits between a fixed-off-time chopping timer and the gate drivers of one full H-bridge. On every clock it decides which of the four bridge transistors (high-side and low-side of leg A and of leg B) may conduct. During the on period it drives the load diagonally according to the commanded current direction. During the off period it picks a recirculation path that depends on a 2-bit rectification policy and on whether the timer is in its fast or slow decay portion.

Two of the policies end rectification early. One stops as soon as the load current reaches zero, so the current cannot reverse. The other lets the current reverse but stops once the reversed current reaches the limit. After such an event every transistor stays off for the rest of that off period. A global disable overrides everything. All outputs are registered, so each output follows its inputs one clock later.

Top module: `sr_rect_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, all four gate enables and the direction output are 0.
- R2: While off_active is 0, in every mode, direction 1 enables high-side A and low-side B, and direction 0 enables high-side B and low-side A, one clock after the inputs.
- R3: Mode encoding is 00 active, 01 disabled, 10 passive, 11 low-side only. In modes 00 and 10 during fast decay, the diagonal opposite to the on-time diagonal is enabled: high-side B and low-side A for direction 1, and high-side A and low-side B for direction 0.
- R4: In modes 00 and 10 during slow decay, both low-side transistors are enabled and both high-side transistors are off, for either direction.
- R5: In mode 01, no transistor is enabled during the off period.
- R6: In mode 11 the low side is the one chopped. During fast decay only the low-side transistor of the leg whose high side was on is enabled (A for direction 1, B for direction 0). During slow decay only the on-time high-side transistor stays enabled.
- R7: In mode 00, a zero-current flag during the off period turns all outputs off one clock later. The reverse-limit flag has no effect in this mode.
- R8: In mode 10, a reverse-limit flag during the off period turns all outputs off one clock later. The zero-current flag has no effect in this mode.
- R9: In modes 01 and 11, neither the zero-current flag nor the reverse-limit flag changes the outputs.
- R10: Once rectification has been stopped, the outputs stay off until off_active returns to 0. The next off period rectifies again.
- R11: When disable_all is 1, all four gate enables are 0 one clock later, whatever the other inputs are.
- R12: The high-side and low-side enables of the same leg are never 1 together.
- R13: dir_out equals the direction input delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Rectification policy (00 active, 01 disabled, 10 passive, 11 low-side only) |
| direction | input | 1 | Commanded current direction (1 drives A high, B low) |
| off_active | input | 1 | Chopping timer is in its off period |
| fast_decay | input | 1 | Off period is in its fast-decay portion (0 means slow) |
| zero_det | input | 1 | Load current has reached zero |
| rev_limit | input | 1 | Reversed current has reached the limit |
| disable_all | input | 1 | Forces all gate enables off |
| hs_a | output | 1 | High-side enable, leg A |
| ls_a | output | 1 | Low-side enable, leg A |
| hs_b | output | 1 | High-side enable, leg B |
| ls_b | output | 1 | Low-side enable, leg B |
| dir_out | output | 1 | Registered direction |

## Verification
The assertions assume that every input is synchronous to clk and stable across each rising edge. They also assume that the early-stop flags matter only while off_active is high, so a flag raised during the on period has no lasting effect. The directed stimulus changes inputs only on falling edges and raises the stop flags only inside off periods. It also returns off_active to 0 before it checks that rectification resumes, so the properties are never exercised outside what they assume.

// File: rtl/sr_rect_pkg.sv
package sr_rect_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    SR_ACTIVE   = 2'b00,
    SR_DISABLED = 2'b01,
    SR_PASSIVE  = 2'b10,
    SR_LOWSIDE  = 2'b11
  } sr_mode_e;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_t;

  localparam gate_t GATES_OFF = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};
endpackage

// File: rtl/sr_term_latch.sv
module sr_term_latch
  import sr_rect_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sr_mode_e mode,
  input  logic     off_active,
  input  logic     zero_det,
  input  logic     rev_limit,
  output logic     stop_now
);
  logic stop_q;
  logic event_hit;

  always_comb begin
    unique case (mode)
      SR_ACTIVE:  event_hit = zero_det;
      SR_PASSIVE: event_hit = rev_limit;
      default:    event_hit = 1'b0;
    endcase
  end

  assign stop_now = off_active & (stop_q | event_hit);

  always_ff @(posedge clk) begin
    if (rst)             stop_q <= 1'b0;
    else if (off_active) stop_q <= stop_q | event_hit;
    else                 stop_q <= 1'b0;
  end

  // Once stopped, the latch holds while the off period continues
  assert_stop_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (stop_q && off_active) |=> stop_q);

  // A new on period always clears the latch
  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !off_active |=> !stop_q);
endmodule

// File: rtl/sr_gate_map.sv
module sr_gate_map
  import sr_rect_pkg::*;
(
  input  sr_mode_e mode,
  input  logic     direction,
  input  logic     off_active,
  input  logic     fast_decay,
  input  logic     stop_now,
  input  logic     disable_all,
  output gate_t    gates
);
  gate_t diag_fwd;
  gate_t diag_rev;
  gate_t off_pat;

  assign diag_fwd = '{hs_a: 1'b1, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b1};
  assign diag_rev = '{hs_a: 1'b0, ls_a: 1'b1, hs_b: 1'b1, ls_b: 1'b0};

  always_comb begin
    off_pat = GATES_OFF;
    unique case (mode)
      SR_DISABLED: off_pat = GATES_OFF;
      SR_LOWSIDE: begin
        if (fast_decay) begin
          off_pat.ls_a = direction;
          off_pat.ls_b = ~direction;
        end else begin
          off_pat.hs_a = direction;
          off_pat.hs_b = ~direction;
        end
      end
      default: begin
        if (fast_decay) off_pat = direction ? diag_rev : diag_fwd;
        else            off_pat = '{hs_a: 1'b0, ls_a: 1'b1, hs_b: 1'b0, ls_b: 1'b1};
      end
    endcase
  end

  always_comb begin
    if (disable_all)     gates = GATES_OFF;
    else if (!off_active) gates = direction ? diag_fwd : diag_rev;
    else if (stop_now)   gates = GATES_OFF;
    else                 gates = off_pat;
  end
endmodule

// File: rtl/sr_rect_ctrl.sv
module sr_rect_ctrl
  import sr_rect_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       direction,
  input  logic       off_active,
  input  logic       fast_decay,
  input  logic       zero_det,
  input  logic       rev_limit,
  input  logic       disable_all,
  output logic       hs_a,
  output logic       ls_a,
  output logic       hs_b,
  output logic       ls_b,
  output logic       dir_out
);
  sr_mode_e mode_e;
  logic     stop_now;
  gate_t    gates_nxt;
  gate_t    gates_q;

  assign mode_e = sr_mode_e'(mode);

  sr_term_latch u_term (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_e),
    .off_active (off_active),
    .zero_det   (zero_det),
    .rev_limit  (rev_limit),
    .stop_now   (stop_now)
  );

  sr_gate_map u_map (
    .mode        (mode_e),
    .direction   (direction),
    .off_active  (off_active),
    .fast_decay  (fast_decay),
    .stop_now    (stop_now),
    .disable_all (disable_all),
    .gates       (gates_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gates_q <= GATES_OFF;
      dir_out <= 1'b0;
    end else begin
      gates_q <= gates_nxt;
      dir_out <= direction;
    end
  end

  assign hs_a = gates_q.hs_a;
  assign ls_a = gates_q.ls_a;
  assign hs_b = gates_q.hs_b;
  assign ls_b = gates_q.ls_b;

  assert_leg_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(hs_a && ls_a) && !(hs_b && ls_b));

  assert_disable_off_R11: assert property (@(posedge clk) disable iff (rst)
    disable_all |=> !(hs_a || ls_a || hs_b || ls_b));

  assert_disabled_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && off_active) |=> !(hs_a || ls_a || hs_b || ls_b));

  assert_on_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (!off_active && !disable_all && direction) |=> (hs_a && ls_b && !hs_b && !ls_a));

  assert_dir_follow_R13: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dir_out == $past(direction)));
endmodule

// File: tb/sr_rect_ctrl_test.sv
module sr_rect_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic direction = 1'b0;
  logic off_active = 1'b0;
  logic fast_decay = 1'b0;
  logic zero_det = 1'b0;
  logic rev_limit = 1'b0;
  logic disable_all = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b, dir_out;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_rect_ctrl uut (
    .clk(clk), .rst(rst), .mode(mode), .direction(direction),
    .off_active(off_active), .fast_decay(fast_decay), .zero_det(zero_det),
    .rev_limit(rev_limit), .disable_all(disable_all),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .dir_out(dir_out)
  );

  // expected is {hs_a, ls_a, hs_b, ls_b, dir_out}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {hs_a, ls_a, hs_b, ls_b, dir_out};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
    checks++;
    if ((hs_a && ls_a) || (hs_b && ls_b)) begin
      errors++;
      $display("FAIL R12: got %b expected no leg shoot-through", act);
    end
  endtask

  // drive at a falling edge, then sample at the next falling edge
  task automatic step(input logic [1:0] m, input logic ph, input logic off,
                      input logic fast, input logic zd, input logic rl, input logic dis);
    mode = m; direction = ph; off_active = off; fast_decay = fast;
    zero_det = zd; rev_limit = rl; disable_all = dis;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1", 5'b00000);
    rst = 1'b0;
  endtask

  task automatic t_on_period;
    for (int m = 0; m < 4; m++) begin
      step(2'(m), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2", 5'b10011);
      step(2'(m), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R2", 5'b01100);
    end
  endtask

  task automatic t_fast_slow;
    step(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R3", 5'b01101);
    step(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R3", 5'b10010);
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R4", 5'b01011);
    step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R4", 5'b01010);
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_disabled_mode;
    step(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R5", 5'b00001);
    step(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R5", 5'b00000);
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lowside;
    step(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R6", 5'b01001);
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R6", 5'b10001);
    step(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R6", 5'b00010);
    step(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R6", 5'b00100);
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_active_stop;
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); chk("R7", 5'b01011);
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); chk("R7", 5'b00001);
    step(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R10", 5'b00001);
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); chk("R10", 5'b10011);
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R10", 5'b01011);
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_passive_stop;
    step(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); chk("R8", 5'b10010);
    step(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0); chk("R8", 5'b00000);
    step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R10", 5'b00000);
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); chk("R10", 5'b01100);
    step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); chk("R10", 5'b01010);
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_flags_ignored;
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); chk("R9", 5'b10001);
    step(2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); chk("R9", 5'b01001);
    step(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); chk("R9", 5'b00001);
    step(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); chk("R9", 5'b10011);
  endtask

  task automatic t_disable;
    step(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); chk("R11", 5'b00001);
    step(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); chk("R11", 5'b00000);
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); chk("R11", 5'b00001);
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); chk("R11", 5'b10011);
  endtask

  task automatic t_direction;
    step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); chk("R13", 5'b00000);
    step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); chk("R13", 5'b00001);
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); chk("R13", 5'b01100);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_on_period();
    t_fast_slow();
    t_disabled_mode();
    t_lowside();
    t_active_stop();
    t_passive_stop();
    t_flags_ignored();
    t_disable();
    t_direction();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule